// File: doc/BRIEF.md
# Multi-Mode Composite Sync Generator

This block produces the composite sync for a raster video timing chain. A pixel counter and a line counter inside the block walk each line and each field. Every pixel is placed in one of these regions: the active region, the vertical front porch, a nine-line vertical interval or the back-porch lines. The block then shapes one active-high sync bit per pixel from that region. It also gives out a line-drive strobe, a field-drive strobe and a blanking level, all from the same counters.

Three static control pins set the waveform style:
- **All pins low (full style):** the vertical interval carries equalizing pulses and a serrated vertical pulse at twice line rate.
- **Equalizing and serrations disabled (simplified style):** the equalizing lines carry plain line-rate pulses and the vertical pulse is one solid block.
- **All three pins high (restricted style):** the vertical front porch carries no sync, and the line-rate pulses lose their horizontal front porch. Each pulse then starts where line blanking starts.

The deletion pin alone blanks sync across the vertical front porch. The mode pins are sampled only on the last pixel of a field, so a field is always built in a single style. The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or timing level.

Top module: `csync_gen`

## Requirements
- R1: On a line-rate line (active region, back-porch lines, front-porch lines when deletion is off), `csync` is high for pixels 0 to HSYNC_W-1 and low for the rest of the line. The one exception is R7.
- R2: In full style, vertical-interval lines 1–3 and 7–9 carry two pulses of width HSYNC_W/2, starting at pixel 0 and at pixel LINE_LEN/2.
- R3: In full style, vertical-interval lines 4–6 are high except for two gaps of SER_W pixels each. One gap ends at pixel LINE_LEN/2 and the other ends at the end of the line.
- R4: With `eq_off` high, vertical-interval lines 1–3 and 7–9 carry a single R1 line-rate pulse and nothing at mid-line.
- R5: With `ser_off` high, vertical-interval lines 4–6 are high on every pixel.
- R6: With `fp_del` high, the vertical front-porch lines (ACTIVE_LINES to ACTIVE_LINES+VFP_LINES-1) carry no sync.
- R7: In restricted style (all three pins high), the last HFP_W pixels of a line are high exactly when the next line is a line-rate line or a vertical-pulse line. In every other style, those pixels are low on line-rate lines.
- R8: The mode pins are captured only on the last pixel of a field. A pin change inside a field does not affect that field.
- R9: `h_drive` is high for exactly one pixel per line, at pixel LINE_LEN-HFP_W. `v_drive` is high for exactly one pixel per field, at pixel 0 of vertical-interval line 1.
- R10: `blank` is high on every pixel of lines ACTIVE_LINES and above. On active lines, it is high for pixels below HB_END and for pixels from LINE_LEN-HFP_W upward.
- R11: While `rst` is high, all outputs are low and the counters hold at line 0, pixel 0. The first clock edge after reset outputs the value for line 0, pixel 0, with the mode set to full style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| eq_off | input | 1 | Replaces the equalizing pulses with line-rate pulses |
| ser_off | input | 1 | Makes the vertical pulse solid, with no serrations |
| fp_del | input | 1 | Removes sync across the vertical front porch |
| csync | output | 1 | Composite sync, registered, active high |
| h_drive | output | 1 | One-pixel strobe at the start of line blanking |
| v_drive | output | 1 | One-pixel strobe at the start of the vertical interval |
| blank | output | 1 | Composite blanking level |

## Verification
All four outputs are registered from the counter state. The value for pixel position n, counted from the first edge after reset, is therefore visible just after clock edge n+1. The bench keeps its own edge count and samples on the falling edge at exactly that position.

A mode change is due one field later, not some cycles later. After changing the pins, the bench waits for a complete field boundary before it checks the new style. One directed case checks a point later in the same field, confirming that the old style is still in force.

// File: rtl/csg_pkg.sv
package csg_pkg;
  typedef enum logic [1:0] {
    LC_LINE  = 2'd0,
    LC_EQ    = 2'd1,
    LC_VS    = 2'd2,
    LC_QUIET = 2'd3
  } line_cls_e;

  typedef struct packed {
    logic eq_off;
    logic ser_off;
    logic fp_del;
  } mode_t;
endpackage

// File: rtl/csg_timebase.sv
module csg_timebase #(
  parameter int LINE_LEN = 64,
  parameter int LINES    = 26,
  localparam int HW = $clog2(LINE_LEN),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic [LW-1:0] lcnt,
  output logic [LW-1:0] lnext,
  output logic          field_end
);
  localparam logic [HW-1:0] H_LAST = HW'(LINE_LEN - 1);
  localparam logic [LW-1:0] L_LAST = LW'(LINES - 1);

  always_comb begin
    lnext     = (lcnt == L_LAST) ? '0 : lcnt + 1'b1;
    field_end = (hcnt == H_LAST) && (lcnt == L_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      lcnt <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      lcnt <= lnext;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  a_r11_pixel_range: assert property (@(posedge clk) disable iff (rst)
    hcnt <= H_LAST);
  a_r11_line_range: assert property (@(posedge clk) disable iff (rst)
    lcnt <= L_LAST);
  a_r11_field_wrap: assert property (@(posedge clk) disable iff (rst)
    field_end |=> (lcnt == '0 && hcnt == '0));
endmodule

// File: rtl/csg_mode_latch.sv
module csg_mode_latch
  import csg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  field_end,
  input  mode_t mode_in,
  output mode_t mode_q
);
  always_ff @(posedge clk) begin
    if (rst)            mode_q <= '0;
    else if (field_end) mode_q <= mode_in;
  end

  a_r8_mode_holds: assert property (@(posedge clk) disable iff (rst)
    !field_end |=> $stable(mode_q));
endmodule

// File: rtl/csg_line_class.sv
module csg_line_class
  import csg_pkg::*;
#(
  parameter int ACTIVE_LINES = 10,
  parameter int VFP_LINES    = 3,
  parameter int LW           = 5
) (
  input  logic [LW-1:0] line,
  input  logic          eq_off,
  input  logic          fp_del,
  output line_cls_e     cls
);
  localparam logic [LW-1:0] L_ACT = LW'(ACTIVE_LINES);
  localparam logic [LW-1:0] L_VI0 = LW'(ACTIVE_LINES + VFP_LINES);
  localparam logic [LW-1:0] L_VS0 = LW'(ACTIVE_LINES + VFP_LINES + 3);
  localparam logic [LW-1:0] L_EQ2 = LW'(ACTIVE_LINES + VFP_LINES + 6);
  localparam logic [LW-1:0] L_END = LW'(ACTIVE_LINES + VFP_LINES + 9);

  always_comb begin
    cls = LC_LINE;
    if (line >= L_ACT && line < L_VI0)
      cls = fp_del ? LC_QUIET : LC_LINE;
    else if ((line >= L_VI0 && line < L_VS0) || (line >= L_EQ2 && line < L_END))
      cls = eq_off ? LC_LINE : LC_EQ;
    else if (line >= L_VS0 && line < L_EQ2)
      cls = LC_VS;
  end
endmodule

// File: rtl/csg_shaper.sv
module csg_shaper
  import csg_pkg::*;
#(
  parameter int LINE_LEN     = 64,
  parameter int HSYNC_W      = 6,
  parameter int HFP_W        = 2,
  parameter int SER_W        = 4,
  parameter int HB_END       = 12,
  parameter int ACTIVE_LINES = 10,
  parameter int VFP_LINES    = 3,
  parameter int HW           = 6,
  parameter int LW           = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hcnt,
  input  logic [LW-1:0] lcnt,
  input  line_cls_e     cls_cur,
  input  line_cls_e     cls_nxt,
  input  mode_t         mode,
  output logic          csync,
  output logic          h_drive,
  output logic          v_drive,
  output logic          blank
);
  localparam int EQ_W = HSYNC_W / 2;
  localparam logic [HW-1:0] P_HS   = HW'(HSYNC_W);
  localparam logic [HW-1:0] P_EQ   = HW'(EQ_W);
  localparam logic [HW-1:0] P_HALF = HW'(LINE_LEN / 2);
  localparam logic [HW-1:0] P_HEQ  = HW'(LINE_LEN / 2 + EQ_W);
  localparam logic [HW-1:0] P_SER0 = HW'(LINE_LEN / 2 - SER_W);
  localparam logic [HW-1:0] P_SER1 = HW'(LINE_LEN - SER_W);
  localparam logic [HW-1:0] P_TAIL = HW'(LINE_LEN - HFP_W);
  localparam logic [HW-1:0] P_HBE  = HW'(HB_END);
  localparam logic [LW-1:0] L_ACT  = LW'(ACTIVE_LINES);
  localparam logic [LW-1:0] L_VI0  = LW'(ACTIVE_LINES + VFP_LINES);

  logic tail, restricted, sync_d;

  always_comb begin
    tail       = (hcnt >= P_TAIL);
    restricted = mode.eq_off & mode.ser_off & mode.fp_del;
    unique case (cls_cur)
      LC_LINE:  sync_d = (hcnt < P_HS);
      LC_EQ:    sync_d = (hcnt < P_EQ) || (hcnt >= P_HALF && hcnt < P_HEQ);
      LC_VS:    sync_d = mode.ser_off ||
                         !((hcnt >= P_SER0 && hcnt < P_HALF) || hcnt >= P_SER1);
      default:  sync_d = 1'b0;
    endcase
    if (restricted && tail)
      sync_d = (cls_nxt == LC_LINE) || (cls_nxt == LC_VS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csync   <= 1'b0;
      h_drive <= 1'b0;
      v_drive <= 1'b0;
      blank   <= 1'b0;
    end else begin
      csync   <= sync_d;
      h_drive <= (hcnt == P_TAIL);
      v_drive <= (lcnt == L_VI0) && (hcnt == '0);
      blank   <= (lcnt >= L_ACT) || tail || (hcnt < P_HBE);
    end
  end

  a_r9_hdrive_single: assert property (@(posedge clk) disable iff (rst)
    h_drive |=> !h_drive);
  a_r9_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(h_drive && v_drive));
  a_r6_porch_quiet: assert property (@(posedge clk) disable iff (rst)
    (cls_cur == LC_QUIET && !tail) |=> !csync);
  a_r5_solid_vs: assert property (@(posedge clk) disable iff (rst)
    (cls_cur == LC_VS && mode.ser_off) |=> csync);
  a_r7_no_lead_in: assert property (@(posedge clk) disable iff (rst)
    (restricted && tail && cls_nxt == LC_QUIET) |=> !csync);
  a_r10_blank_on_sync: assert property (@(posedge clk) disable iff (rst)
    h_drive |-> blank);
endmodule

// File: rtl/csync_gen.sv
module csync_gen
  import csg_pkg::*;
#(
  parameter int LINE_LEN     = 64,
  parameter int HSYNC_W      = 6,
  parameter int HFP_W        = 2,
  parameter int SER_W        = 4,
  parameter int HB_END       = 12,
  parameter int ACTIVE_LINES = 10,
  parameter int VFP_LINES    = 3,
  parameter int LINES        = 26
) (
  input  logic clk,
  input  logic rst,
  input  logic eq_off,
  input  logic ser_off,
  input  logic fp_del,
  output logic csync,
  output logic h_drive,
  output logic v_drive,
  output logic blank
);
  localparam int HW = $clog2(LINE_LEN);
  localparam int LW = $clog2(LINES);

  logic [HW-1:0] hcnt;
  logic [LW-1:0] lcnt, lnext;
  logic          field_end;
  mode_t         mode_in, mode_q;
  line_cls_e     cls [2];
  logic [LW-1:0] cls_line [2];

  assign mode_in     = '{eq_off: eq_off, ser_off: ser_off, fp_del: fp_del};
  assign cls_line[0] = lcnt;
  assign cls_line[1] = lnext;

  csg_timebase #(.LINE_LEN(LINE_LEN), .LINES(LINES)) u_tb (
    .clk(clk), .rst(rst), .hcnt(hcnt), .lcnt(lcnt), .lnext(lnext),
    .field_end(field_end)
  );

  csg_mode_latch u_mode (
    .clk(clk), .rst(rst), .field_end(field_end), .mode_in(mode_in), .mode_q(mode_q)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cls
    csg_line_class #(
      .ACTIVE_LINES(ACTIVE_LINES), .VFP_LINES(VFP_LINES), .LW(LW)
    ) u_cls (
      .line(cls_line[g]), .eq_off(mode_q.eq_off), .fp_del(mode_q.fp_del),
      .cls(cls[g])
    );
  end

  csg_shaper #(
    .LINE_LEN(LINE_LEN), .HSYNC_W(HSYNC_W), .HFP_W(HFP_W), .SER_W(SER_W),
    .HB_END(HB_END), .ACTIVE_LINES(ACTIVE_LINES), .VFP_LINES(VFP_LINES),
    .HW(HW), .LW(LW)
  ) u_shape (
    .clk(clk), .rst(rst), .hcnt(hcnt), .lcnt(lcnt), .cls_cur(cls[0]),
    .cls_nxt(cls[1]), .mode(mode_q), .csync(csync), .h_drive(h_drive),
    .v_drive(v_drive), .blank(blank)
  );
endmodule

// File: tb/csync_gen_tb.sv
module csync_gen_tb_top;
  localparam int LINE  = 64;
  localparam int LINES = 26;
  localparam int FIELD = LINE * LINES;
  localparam int NV    = 39;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eq_off = 1'b0, ser_off = 1'b0, fp_del = 1'b0;
  logic csync, h_drive, v_drive, blank;
  int   cyc = 0;
  int   checks = 0, errors = 0;
  logic [2:0] applied = 3'b000;
  bit   have_mode = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  csync_gen dut_i (
    .clk(clk), .rst(rst), .eq_off(eq_off), .ser_off(ser_off), .fp_del(fp_del),
    .csync(csync), .h_drive(h_drive), .v_drive(v_drive), .blank(blank)
  );

  // {mode eq/ser/fp, sel 0=csync 1=h_drive 2=v_drive 3=blank, line, pixel, expected, req}
  localparam logic [22:0] VEC [NV] = '{
    {3'b000,2'd0,6'd2 ,7'd5 ,1'b1,4'd1},   // R1
    {3'b000,2'd0,6'd2 ,7'd6 ,1'b0,4'd1},   // R1
    {3'b000,2'd0,6'd2 ,7'd62,1'b0,4'd7},   // R7 porch kept
    {3'b000,2'd1,6'd3 ,7'd62,1'b1,4'd9},   // R9
    {3'b000,2'd1,6'd3 ,7'd63,1'b0,4'd9},   // R9
    {3'b000,2'd3,6'd5 ,7'd11,1'b1,4'd10},  // R10
    {3'b000,2'd3,6'd5 ,7'd12,1'b0,4'd10},  // R10
    {3'b000,2'd3,6'd5 ,7'd30,1'b0,4'd10},  // R10
    {3'b000,2'd3,6'd10,7'd30,1'b1,4'd10},  // R10
    {3'b000,2'd0,6'd11,7'd0 ,1'b1,4'd6},   // R6 deletion off
    {3'b000,2'd2,6'd13,7'd0 ,1'b1,4'd9},   // R9
    {3'b000,2'd2,6'd13,7'd1 ,1'b0,4'd9},   // R9
    {3'b000,2'd0,6'd13,7'd2 ,1'b1,4'd2},   // R2
    {3'b000,2'd0,6'd13,7'd3 ,1'b0,4'd2},   // R2
    {3'b000,2'd0,6'd13,7'd32,1'b1,4'd2},   // R2
    {3'b000,2'd0,6'd13,7'd35,1'b0,4'd2},   // R2
    {3'b000,2'd0,6'd16,7'd10,1'b1,4'd3},   // R3
    {3'b000,2'd0,6'd16,7'd27,1'b1,4'd3},   // R3
    {3'b000,2'd0,6'd16,7'd28,1'b0,4'd3},   // R3
    {3'b000,2'd0,6'd16,7'd32,1'b1,4'd3},   // R3
    {3'b000,2'd0,6'd16,7'd60,1'b0,4'd3},   // R3
    {3'b000,2'd0,6'd20,7'd33,1'b1,4'd2},   // R2
    {3'b110,2'd0,6'd13,7'd5 ,1'b1,4'd4},   // R4
    {3'b110,2'd0,6'd13,7'd32,1'b0,4'd4},   // R4
    {3'b110,2'd0,6'd16,7'd61,1'b1,4'd5},   // R5
    {3'b110,2'd0,6'd17,7'd29,1'b1,4'd5},   // R5
    {3'b110,2'd0,6'd20,7'd34,1'b0,4'd4},   // R4
    {3'b001,2'd0,6'd9 ,7'd0 ,1'b1,4'd6},   // R6
    {3'b001,2'd0,6'd10,7'd2 ,1'b0,4'd6},   // R6
    {3'b001,2'd0,6'd11,7'd0 ,1'b0,4'd6},   // R6
    {3'b001,2'd0,6'd13,7'd2 ,1'b1,4'd2},   // R2
    {3'b111,2'd0,6'd2 ,7'd61,1'b0,4'd7},   // R7
    {3'b111,2'd0,6'd2 ,7'd62,1'b1,4'd7},   // R7
    {3'b111,2'd0,6'd5 ,7'd5 ,1'b1,4'd7},   // R7
    {3'b111,2'd0,6'd9 ,7'd62,1'b0,4'd7},   // R7
    {3'b111,2'd0,6'd11,7'd62,1'b0,4'd7},   // R7
    {3'b111,2'd0,6'd12,7'd62,1'b1,4'd7},   // R7
    {3'b111,2'd0,6'd15,7'd62,1'b1,4'd7},   // R7
    {3'b111,2'd0,6'd21,7'd40,1'b0,4'd7}    // R7
  };

  function automatic logic pick(input logic [1:0] sel);
    case (sel)
      2'd0:    pick = csync;
      2'd1:    pick = h_drive;
      2'd2:    pick = v_drive;
      default: pick = blank;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic wait_pos(input int target);
    while (cyc - 1 != target) @(negedge clk);
  endtask

  task automatic goto(input logic [2:0] m, input int line, input int pix);
    int p, f, off;
    p   = cyc - 1;
    f   = p / FIELD;
    off = line * LINE + pix;
    if (!have_mode || m != applied) begin
      {eq_off, ser_off, fp_del} = m;
      applied   = m;
      have_mode = 1'b1;
      f = f + 2;
    end else if (f * FIELD + off <= p) begin
      f = f + 1;
    end
    wait_pos(f * FIELD + off);
  endtask

  initial begin
    int f;
    repeat (3) @(negedge clk);
    check(csync, 1'b0, "R11", "csync in reset");
    check(blank, 1'b0, "R11", "blank in reset");
    rst = 1'b0;
    @(negedge clk);
    check(csync, 1'b1, "R11", "first pixel sync");
    check(blank, 1'b1, "R11", "first pixel blank");

    for (int i = 0; i < NV; i++) begin
      goto(VEC[i][22:20], int'(VEC[i][17:12]), int'(VEC[i][11:5]));
      check(pick(VEC[i][19:18]), VEC[i][4], $sformatf("R%0d", VEC[i][3:0]),
            $sformatf("vec %0d line %0d pix %0d", i, VEC[i][17:12], VEC[i][11:5]));
    end

    // R8: mid-field pin change must wait for the field boundary
    goto(3'b000, 14, 0);
    ser_off = 1'b1;
    f = (cyc - 1) / FIELD;
    wait_pos(f * FIELD + 17 * LINE + 29);
    check(csync, 1'b0, "R8", "serration gap kept in same field");
    wait_pos((f + 1) * FIELD + 17 * LINE + 29);
    check(csync, 1'b1, "R8", "solid pulse in next field");
    applied = 3'b010;

    // R11: reset mid-run restarts at line 0 pixel 0 in full style
    eq_off = 1'b1; fp_del = 1'b1;
    wait_pos((f + 1) * FIELD + 17 * LINE + 40);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(csync, 1'b0, "R11", "csync held low");
    check(h_drive, 1'b0, "R11", "h_drive held low");
    check(v_drive, 1'b0, "R11", "v_drive held low");
    rst = 1'b0;
    @(negedge clk);
    check(csync, 1'b1, "R11", "restart pixel 0");
    wait_pos(62);
    check(csync, 1'b0, "R11", "full style after reset, porch low");
    check(h_drive, 1'b1, "R9", "h_drive after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule